// File: doc/BRIEF.md
# Pipeline Forwarding and Interlock Controller

This block resolves data and control hazards for a five-stage in-order pipeline: fetch, operand fetch/decode, execute, memory access and register write-back, with one latch between each pair of neighbouring stages. It looks at the source and destination register fields and the flags held in those latches. From them it drives the select lines of six operand forwarding multiplexers, a front-end stall, bubble insertion and the flush and fetch-redirect controls. The unit is purely combinational, so every output follows the latch contents within the same cycle.

Four forwarding paths exist: memory access to execute, and write-back to each of execute, memory access and operand fetch. A value is forwarded at the last stage that still needs it. A store's data operand is therefore never taken from the memory-access latch into execute. It is instead picked up from write-back, either in execute or, one cycle later, in memory access. A load followed at once by an ALU use of its result stalls the front end for exactly one cycle. A taken branch, resolved in execute, cancels the two younger instructions and redirects fetch.

Top module: `fwd_interlock_ctl`

## Requirements
- R1: For an execute-stage ALU operand (A, or B when B is not marked late), the select is 2'b01 (from memory access) when the valid memory-access latch writes that register. It is 2'b10 (from write-back) when only the valid write-back latch writes it, and 2'b00 otherwise. Memory access wins when both write it.
- R2: A latch that is invalid, or whose destination enable is low, never causes a forward or a stall. A source whose enable is low never matches.
- R3: An operand-fetch source A or B has its select at 1 exactly when the valid write-back latch writes that register.
- R4: The memory-access store-data select is 1 when the store-data enable is set and the valid write-back latch writes that register. A load directly ahead of a store of the loaded register therefore gets the value through this path with no stall.
- R5: An execute-stage B operand marked late (store data) never uses the memory-access path. Its ALU select stays 2'b00, and its store-data select is 1 only when the valid write-back latch writes that register.
- R6: When the valid execute latch holds a load with a destination, and the valid operand-fetch instruction uses that register as source A, or as a non-late source B, the stall output and the execute bubble output are both 1.
- R7: A load in execute followed by an instruction that uses the loaded register only as a late (store-data) source B raises no stall.
- R8: A valid execute-stage branch with its taken flag set drives redirect, kill of the fetch/decode latch and the execute bubble all to 1.
- R9: When a taken branch is signalled, stall is 0 even if the load-use condition also holds.
- R10: A branch that is not taken, or a taken flag on a non-branch or invalid execute latch, drives no redirect, kill or bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded checks |
| rst_n | input | 1 | Active-low reset for the embedded checks |
| of_valid | input | 1 | Operand-fetch latch holds an instruction |
| of_a | input | REG_W | Operand-fetch source A register |
| of_a_en | input | 1 | Source A is read |
| of_b | input | REG_W | Operand-fetch source B register |
| of_b_en | input | 1 | Source B is read |
| of_b_late | input | 1 | Source B is store data, consumed in memory access |
| ex_valid | input | 1 | Execute latch holds an instruction |
| ex_a | input | REG_W | Execute source A register |
| ex_a_en | input | 1 | Execute source A is read |
| ex_b | input | REG_W | Execute source B register |
| ex_b_en | input | 1 | Execute source B is read |
| ex_b_late | input | 1 | Execute source B is store data |
| ex_dst_en | input | 1 | Execute instruction writes a register |
| ex_dst | input | REG_W | Execute destination register |
| ex_is_load | input | 1 | Execute instruction is a load |
| ex_is_branch | input | 1 | Execute instruction is a branch |
| ex_taken | input | 1 | Branch outcome from execute: taken |
| ma_valid | input | 1 | Memory-access latch holds an instruction |
| ma_d | input | REG_W | Store-data register in memory access |
| ma_d_en | input | 1 | Memory-access instruction is a store needing data |
| ma_dst_en | input | 1 | Memory-access instruction writes a register |
| ma_dst | input | REG_W | Memory-access destination register |
| rw_valid | input | 1 | Write-back latch holds an instruction |
| rw_dst_en | input | 1 | Write-back instruction writes a register |
| rw_dst | input | REG_W | Write-back destination register |
| fwd_of_a | output | 1 | Operand-fetch A from write-back |
| fwd_of_b | output | 1 | Operand-fetch B from write-back |
| fwd_ex_a | output | 2 | Execute A select: 00 latch, 01 memory access, 10 write-back |
| fwd_ex_b | output | 2 | Execute B select, same encoding |
| fwd_ex_d | output | 1 | Execute store data from write-back |
| fwd_ma_d | output | 1 | Memory-access store data from write-back |
| stall_front | output | 1 | Hold the PC and the fetch/decode latch |
| bubble_ex | output | 1 | Load a nop into the decode/execute latch |
| kill_of | output | 1 | Load a nop into the fetch/decode latch |
| redirect | output | 1 | Redirect fetch to the branch target |

## Verification
The forwarding selects are tried with a dependent pair whose producer sits one, two and three instructions ahead. Comparing these shows which of the memory-access, write-back-to-execute and write-back-to-operand-fetch paths is chosen, and two writers of one register show the priority. Load-use is set against load-then-store, which separates an ALU use that must stall from a store-data use that must not. Taken and not-taken branches, and a taken flag on a non-branch, separate a true flush from spurious ones, and a taken load-flagged branch shows flush beating stall.

// File: rtl/fwd_interlock_ctl.sv
module fwd_interlock_ctl #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             of_valid,
  input  logic [REG_W-1:0] of_a,
  input  logic             of_a_en,
  input  logic [REG_W-1:0] of_b,
  input  logic             of_b_en,
  input  logic             of_b_late,
  input  logic             ex_valid,
  input  logic [REG_W-1:0] ex_a,
  input  logic             ex_a_en,
  input  logic [REG_W-1:0] ex_b,
  input  logic             ex_b_en,
  input  logic             ex_b_late,
  input  logic             ex_dst_en,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_is_load,
  input  logic             ex_is_branch,
  input  logic             ex_taken,
  input  logic             ma_valid,
  input  logic [REG_W-1:0] ma_d,
  input  logic             ma_d_en,
  input  logic             ma_dst_en,
  input  logic [REG_W-1:0] ma_dst,
  input  logic             rw_valid,
  input  logic             rw_dst_en,
  input  logic [REG_W-1:0] rw_dst,
  output logic             fwd_of_a,
  output logic             fwd_of_b,
  output logic [1:0]       fwd_ex_a,
  output logic [1:0]       fwd_ex_b,
  output logic             fwd_ex_d,
  output logic             fwd_ma_d,
  output logic             stall_front,
  output logic             bubble_ex,
  output logic             kill_of,
  output logic             redirect
);

  localparam logic [1:0] SEL_LATCH = 2'b00;
  localparam logic [1:0] SEL_MA    = 2'b01;
  localparam logic [1:0] SEL_RW    = 2'b10;

  logic ma_wr, rw_wr, ex_ld;
  assign ma_wr = ma_valid & ma_dst_en;
  assign rw_wr = rw_valid & rw_dst_en;
  assign ex_ld = ex_valid & ex_is_load & ex_dst_en;

  logic of_a_use, of_b_use, ex_a_use, ex_b_alu, ex_b_st;
  assign of_a_use = of_valid & of_a_en;
  assign of_b_use = of_valid & of_b_en;
  assign ex_a_use = ex_valid & ex_a_en;
  assign ex_b_alu = ex_valid & ex_b_en & ~ex_b_late;
  assign ex_b_st  = ex_valid & ex_b_en & ex_b_late;

  assign fwd_of_a = of_a_use & rw_wr & (rw_dst == of_a);
  assign fwd_of_b = of_b_use & rw_wr & (rw_dst == of_b);

  logic a_ma, a_rw, b_ma, b_rw;
  assign a_ma = ex_a_use & ma_wr & (ma_dst == ex_a);
  assign a_rw = ex_a_use & rw_wr & (rw_dst == ex_a);
  assign b_ma = ex_b_alu & ma_wr & (ma_dst == ex_b);
  assign b_rw = ex_b_alu & rw_wr & (rw_dst == ex_b);

  assign fwd_ex_a = a_ma ? SEL_MA : (a_rw ? SEL_RW : SEL_LATCH);
  assign fwd_ex_b = b_ma ? SEL_MA : (b_rw ? SEL_RW : SEL_LATCH);

  assign fwd_ex_d = ex_b_st & rw_wr & (rw_dst == ex_b);
  assign fwd_ma_d = ma_valid & ma_d_en & rw_wr & (rw_dst == ma_d);

  logic load_use;
  assign load_use = ex_ld & ((of_a_use & (of_a == ex_dst)) |
                             (of_b_use & ~of_b_late & (of_b == ex_dst)));

  assign redirect    = ex_valid & ex_is_branch & ex_taken;
  assign stall_front = load_use & ~redirect;
  assign bubble_ex   = load_use | redirect;
  assign kill_of     = redirect;

  assert_stall_bubble_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stall_front |-> bubble_ex && !kill_of);

  assert_flush_beats_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> !stall_front);

  assert_flush_kills_R8: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> kill_of && bubble_ex);

  assert_idle_no_fwd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ma_valid && !rw_valid) |-> (fwd_ex_a == SEL_LATCH) && (fwd_ex_b == SEL_LATCH)
                                 && !fwd_of_a && !fwd_of_b && !fwd_ex_d && !fwd_ma_d);

  assert_late_b_no_ma_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_b_late && ex_b_en) |-> fwd_ex_b == SEL_LATCH);

  assert_sel_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_ex_a != 2'b11) && (fwd_ex_b != 2'b11));

endmodule

// File: tb/fwd_interlock_ctl_test.sv
module fwd_interlock_ctl_test;
  localparam int REG_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic of_valid, of_a_en, of_b_en, of_b_late;
  logic [REG_W-1:0] of_a, of_b;
  logic ex_valid, ex_a_en, ex_b_en, ex_b_late, ex_dst_en, ex_is_load, ex_is_branch, ex_taken;
  logic [REG_W-1:0] ex_a, ex_b, ex_dst;
  logic ma_valid, ma_d_en, ma_dst_en;
  logic [REG_W-1:0] ma_d, ma_dst;
  logic rw_valid, rw_dst_en;
  logic [REG_W-1:0] rw_dst;
  logic fwd_of_a, fwd_of_b, fwd_ex_d, fwd_ma_d, stall_front, bubble_ex, kill_of, redirect;
  logic [1:0] fwd_ex_a, fwd_ex_b;

  fwd_interlock_ctl #(.REG_W(REG_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .of_valid(of_valid), .of_a(of_a), .of_a_en(of_a_en), .of_b(of_b), .of_b_en(of_b_en),
    .of_b_late(of_b_late),
    .ex_valid(ex_valid), .ex_a(ex_a), .ex_a_en(ex_a_en), .ex_b(ex_b), .ex_b_en(ex_b_en),
    .ex_b_late(ex_b_late), .ex_dst_en(ex_dst_en), .ex_dst(ex_dst), .ex_is_load(ex_is_load),
    .ex_is_branch(ex_is_branch), .ex_taken(ex_taken),
    .ma_valid(ma_valid), .ma_d(ma_d), .ma_d_en(ma_d_en), .ma_dst_en(ma_dst_en), .ma_dst(ma_dst),
    .rw_valid(rw_valid), .rw_dst_en(rw_dst_en), .rw_dst(rw_dst),
    .fwd_of_a(fwd_of_a), .fwd_of_b(fwd_of_b), .fwd_ex_a(fwd_ex_a), .fwd_ex_b(fwd_ex_b),
    .fwd_ex_d(fwd_ex_d), .fwd_ma_d(fwd_ma_d), .stall_front(stall_front), .bubble_ex(bubble_ex),
    .kill_of(kill_of), .redirect(redirect)
  );

  logic [11:0] exp_q[$];
  string       tag_q[$];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  function automatic logic [11:0] mk(logic oa, logic ob, logic [1:0] xa, logic [1:0] xb,
                                     logic xd, logic md, logic st, logic bx, logic ko, logic rd);
    return {oa, ob, xa, xb, xd, md, st, bx, ko, rd};
  endfunction

  task automatic clr();
    of_valid = 0; of_a = '0; of_a_en = 0; of_b = '0; of_b_en = 0; of_b_late = 0;
    ex_valid = 0; ex_a = '0; ex_a_en = 0; ex_b = '0; ex_b_en = 0; ex_b_late = 0;
    ex_dst_en = 0; ex_dst = '0; ex_is_load = 0; ex_is_branch = 0; ex_taken = 0;
    ma_valid = 0; ma_d = '0; ma_d_en = 0; ma_dst_en = 0; ma_dst = '0;
    rw_valid = 0; rw_dst_en = 0; rw_dst = '0;
  endtask

  task automatic push(string tag, logic [11:0] e);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [11:0] e;
        logic [11:0] got;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        got = {fwd_of_a, fwd_of_b, fwd_ex_a, fwd_ex_b, fwd_ex_d, fwd_ma_d,
               stall_front, bubble_ex, kill_of, redirect};
        checks++;
        if (got !== e) begin
          failures++;
          $display("FAIL %s got=%b exp=%b", t, got, e);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog got=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    clr();
    @(negedge clk);
    push("R2 reset idle", mk(0,0,2'b00,2'b00,0,0,0,0,0,0));
    rst_n = 1'b1;
    @(negedge clk);

    // R1 producer one ahead: add r1 in MA, consumer reads r1 as A in EX
    clr(); ex_valid=1; ex_a=5'd1; ex_a_en=1; ex_b=5'd9; ex_b_en=1;
    ma_valid=1; ma_dst_en=1; ma_dst=5'd1;
    push("R1 ma->ex", mk(0,0,2'b01,2'b00,0,0,0,0,0,0));

    // R1 both MA and RW write r1: MA wins
    clr(); ex_valid=1; ex_b=5'd1; ex_b_en=1;
    ma_valid=1; ma_dst_en=1; ma_dst=5'd1; rw_valid=1; rw_dst_en=1; rw_dst=5'd1;
    push("R1 priority", mk(0,0,2'b00,2'b01,0,0,0,0,0,0));

    // R1 producer two ahead: RW writes r2 for A, MA writes r1 for B
    clr(); ex_valid=1; ex_a=5'd2; ex_a_en=1; ex_b=5'd1; ex_b_en=1;
    ma_valid=1; ma_dst_en=1; ma_dst=5'd1; rw_valid=1; rw_dst_en=1; rw_dst=5'd2;
    push("R1 rw->ex", mk(0,0,2'b10,2'b01,0,0,0,0,0,0));

    // R2 invalid MA writer ignored, RW used
    clr(); ex_valid=1; ex_a=5'd3; ex_a_en=1;
    ma_valid=0; ma_dst_en=1; ma_dst=5'd3; rw_valid=1; rw_dst_en=1; rw_dst=5'd3;
    push("R2 invalid ma", mk(0,0,2'b10,2'b00,0,0,0,0,0,0));

    // R2 no-destination writers and disabled source never match
    clr(); ex_valid=1; ex_a=5'd3; ex_a_en=1; ex_b=5'd4; ex_b_en=0;
    ma_valid=1; ma_dst_en=0; ma_dst=5'd3; rw_valid=1; rw_dst_en=1; rw_dst=5'd4;
    push("R2 no dst", mk(0,0,2'b00,2'b00,0,0,0,0,0,0));

    // R3 producer three ahead: RW writes r7, OF reads r7 as A
    clr(); of_valid=1; of_a=5'd7; of_a_en=1; of_b=5'd8; of_b_en=1;
    rw_valid=1; rw_dst_en=1; rw_dst=5'd7;
    push("R3 rw->of a", mk(1,0,2'b00,2'b00,0,0,0,0,0,0));

    clr(); of_valid=1; of_a=5'd7; of_a_en=1; of_b=5'd8; of_b_en=1; of_b_late=1;
    rw_valid=1; rw_dst_en=1; rw_dst=5'd8;
    push("R3 rw->of b", mk(0,1,2'b00,2'b00,0,0,0,0,0,0));

    // R4 load then store of loaded reg: RW load writes r4, MA store data r4
    clr(); ma_valid=1; ma_d=5'd4; ma_d_en=1; rw_valid=1; rw_dst_en=1; rw_dst=5'd4;
    push("R4 rw->ma", mk(0,0,2'b00,2'b00,0,1,0,0,0,0));

    // R5 store data in EX, writer in MA: no MA forward
    clr(); ex_valid=1; ex_a=5'd2; ex_a_en=1; ex_b=5'd4; ex_b_en=1; ex_b_late=1;
    ma_valid=1; ma_dst_en=1; ma_dst=5'd4;
    push("R5 late no ma", mk(0,0,2'b00,2'b00,0,0,0,0,0,0));

    clr(); ex_valid=1; ex_b=5'd4; ex_b_en=1; ex_b_late=1;
    rw_valid=1; rw_dst_en=1; rw_dst=5'd4;
    push("R5 rw->ex data", mk(0,0,2'b00,2'b00,1,0,0,0,0,0));

    // R6 load-use on A
    clr(); ex_valid=1; ex_is_load=1; ex_dst_en=1; ex_dst=5'd6;
    of_valid=1; of_a=5'd6; of_a_en=1;
    push("R6 load-use a", mk(0,0,2'b00,2'b00,0,0,1,1,0,0));

    // R6 load-use on B
    clr(); ex_valid=1; ex_is_load=1; ex_dst_en=1; ex_dst=5'd6;
    of_valid=1; of_a=5'd1; of_a_en=1; of_b=5'd6; of_b_en=1;
    push("R6 load-use b", mk(0,0,2'b00,2'b00,0,0,1,1,0,0));

    // R7 load then store of loaded reg as data: no stall
    clr(); ex_valid=1; ex_is_load=1; ex_dst_en=1; ex_dst=5'd6;
    of_valid=1; of_a=5'd2; of_a_en=1; of_b=5'd6; of_b_en=1; of_b_late=1;
    push("R7 load-store", mk(0,0,2'b00,2'b00,0,0,0,0,0,0));

    // R2 load-use with invalid OF latch
    clr(); ex_valid=1; ex_is_load=1; ex_dst_en=1; ex_dst=5'd6;
    of_valid=0; of_a=5'd6; of_a_en=1;
    push("R2 bubble of", mk(0,0,2'b00,2'b00,0,0,0,0,0,0));

    // R8 taken branch
    clr(); ex_valid=1; ex_is_branch=1; ex_taken=1;
    push("R8 taken", mk(0,0,2'b00,2'b00,0,0,0,1,1,1));

    // R9 taken flag with load-use condition present
    clr(); ex_valid=1; ex_is_branch=1; ex_taken=1; ex_is_load=1; ex_dst_en=1; ex_dst=5'd5;
    of_valid=1; of_a=5'd5; of_a_en=1;
    push("R9 flush over stall", mk(0,0,2'b00,2'b00,0,0,0,1,1,1));

    // R10 not taken, taken on non-branch, invalid branch
    clr(); ex_valid=1; ex_is_branch=1; ex_taken=0;
    push("R10 not taken", mk(0,0,2'b00,2'b00,0,0,0,0,0,0));
    clr(); ex_valid=1; ex_is_branch=0; ex_taken=1;
    push("R10 non-branch", mk(0,0,2'b00,2'b00,0,0,0,0,0,0));
    clr(); ex_valid=0; ex_is_branch=1; ex_taken=1;
    push("R10 invalid", mk(0,0,2'b00,2'b00,0,0,0,0,0,0));

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule